// File: doc/BRIEF.md
# Scatter-Gather Segment List Walker

This block sits in front of a hash data mover and tells it which memory ranges to read. A command on the start port carries a base address, a length and a mode bit. With the mode bit clear, the block issues one segment built directly from the command's address and length. With the mode bit set, the base address points to a table of 8-byte descriptors in memory. The block reads the table one 32-bit word at a time and turns each descriptor into an (address, length, last) segment on a valid/ready output.

Each descriptor holds a length word followed by an address word. Bit 31 of the length word ends the table. A parameter caps the number of descriptors read in one walk. If the cap is reached and no descriptor carried the end bit, the walk still closes with a final segment and an error pulse. The block keeps at most one memory read in flight. When the final segment is accepted, a one-cycle completion pulse follows.

Top module: `sg_seg_walker`

## Requirements
- R1: After reset, startReady is 1 and memReqValid, segValid, segLast, walkDone and walkErr are all 0.
- R2: With startSgEn = 0, exactly one segment is produced. Its segAddr equals startBase unchanged, its segLen equals startLen[27:0] and segLast is 1. No memory request is issued.
- R3: Descriptor i is read as two word requests. The length word is requested at base + 8·i and the address word at base + 8·i + 4, in that order. Descriptors are read in increasing i.
- R4: A descriptor's segLen is bits 27:0 of its length word, so bits 30:28 have no effect. Bit 31 of the length word set to 1 gives segLast = 1.
- R5: A descriptor's segAddr is its address word with bit 31 forced to 0.
- R6: After the segment with segLast = 1 is accepted, no further memory request is issued. walkDone is high for exactly the one cycle after that acceptance.
- R7: If MAX_ENTRIES descriptors are read and none has bit 31 set, the MAX_ENTRIES-th segment carries segLast = 1, and walkErr pulses together with walkDone. If the end bit is on exactly the MAX_ENTRIES-th descriptor, walkErr stays 0.
- R8: While segValid is 1 and segReady is 0, segValid, segAddr, segLen and segLast hold their values.
- R9: While memReqValid is 1 and memReqReady is 0, memReqValid and memReqAddr hold their values.
- R10: startValid is ignored while a walk is in progress (startReady = 0). The running walk completes with its own segments and memory requests only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start command present |
| startReady | output | 1 | Block idle, command accepted |
| startBase | input | 32 | Table base address, or the segment address in direct mode |
| startLen | input | 32 | Segment length in direct mode (bits 27:0 used) |
| startSgEn | input | 1 | 1 = walk a descriptor table, 0 = single direct segment |
| memReqValid | output | 1 | Word read request |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | 32 | Byte address of the word to read |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Read data word |
| segValid | output | 1 | Segment present |
| segReady | input | 1 | Segment accepted |
| segAddr | output | 32 | Segment start address |
| segLen | output | 28 | Segment length in bytes |
| segLast | output | 1 | Final segment of the walk |
| walkDone | output | 1 | One-cycle pulse after the final segment is accepted |
| walkErr | output | 1 | Pulse with walkDone when the walk hit the entry cap without an end bit |

## Verification
The bench builds the block with MAX_ENTRIES = 4 in place of the default 256. With that value, both the cap-hit error walk and the case where the end bit falls exactly on the capped descriptor take only a handful of descriptors. The bench also turns on periodic stalls on both the memory request ready and the segment ready, so the hold rules on both handshakes are exercised. It also sends a second start command while a walk is running, to show that the command is ignored.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;

  localparam int ADDR_W   = 32;
  localparam int LEN_W    = 28;
  localparam int DESC_BYTES = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_LEN,
    ST_WAIT_LEN,
    ST_REQ_ADDR,
    ST_WAIT_ADDR,
    ST_EMIT
  } walkState_t;

  typedef struct packed {
    logic loadStart;  // latch command fields, clear index
    logic capLen;     // capture length word from response
    logic capAddr;    // capture address word from response
    logic advance;    // step to next descriptor
    logic fetchHi;    // request targets the address word (+4)
  } walkStrobes_t;

endpackage

// File: rtl/sg_walk_dpath.sv
module sg_walk_dpath
  import sg_walk_pkg::*;
#(
  parameter int MAX_ENTRIES = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobes_t       stb,
  input  logic [ADDR_W-1:0]  startBase,
  input  logic [31:0]        startLen,
  input  logic [31:0]        memRspData,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [ADDR_W-1:0]  segAddr,
  output logic [LEN_W-1:0]   segLen,
  output logic               descLast,
  output logic               atCap
);

  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] CAP_IDX = IDX_W'(MAX_ENTRIES - 1);

  logic [ADDR_W-1:0] baseReg;
  logic [IDX_W-1:0]  idxReg;
  logic [31:0]       lenWord;
  logic [ADDR_W-1:0] addrWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      idxReg   <= '0;
      lenWord  <= '0;
      addrWord <= '0;
    end else begin
      if (stb.loadStart) begin
        baseReg  <= startBase;
        idxReg   <= '0;
        // direct mode: a ready-made final segment
        lenWord  <= {1'b1, 3'b000, startLen[LEN_W-1:0]};
        addrWord <= startBase;
      end
      if (stb.capLen)  lenWord  <= memRspData;
      if (stb.capAddr) addrWord <= {1'b0, memRspData[30:0]};
      if (stb.advance) idxReg   <= idxReg + 1'b1;
    end
  end

  assign reqAddr  = baseReg + (ADDR_W'(idxReg) << $clog2(DESC_BYTES))
                  + {{(ADDR_W-3){1'b0}}, stb.fetchHi, 2'b00};
  assign segAddr  = addrWord;
  assign segLen   = lenWord[LEN_W-1:0];
  assign descLast = lenWord[31];
  assign atCap    = (idxReg == CAP_IDX);

  logic unusedBits;
  assign unusedBits = ^{lenWord[30:28], startLen[31:28]};

  // R5: a captured address word never keeps bit 31
  p_addr_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.capAddr |=> !segAddr[31]);

  // R3: stepping to the next descriptor moves the length-word address by 8
  p_stride_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.fetchHi) |=> (reqAddr == $past(reqAddr) + ADDR_W'(DESC_BYTES)));

endmodule

// File: rtl/sg_walk_ctrl.sv
module sg_walk_ctrl
  import sg_walk_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startValid,
  input  logic          startSgEn,
  output logic          startReady,
  output logic          memReqValid,
  input  logic          memReqReady,
  input  logic          memRspValid,
  output logic          segValid,
  input  logic          segReady,
  output logic          segLast,
  output logic          walkDone,
  output logic          walkErr,
  input  logic          descLast,
  input  logic          atCap,
  output walkStrobes_t  stb
);

  walkState_t state, nxt;
  logic finishNow;

  always_comb begin
    nxt         = state;
    stb         = '0;
    startReady  = 1'b0;
    memReqValid = 1'b0;
    segValid    = 1'b0;
    segLast     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        startReady = 1'b1;
        if (startValid) begin
          stb.loadStart = 1'b1;
          nxt = startSgEn ? ST_REQ_LEN : ST_EMIT;
        end
      end
      ST_REQ_LEN: begin
        memReqValid = 1'b1;
        if (memReqReady) nxt = ST_WAIT_LEN;
      end
      ST_WAIT_LEN: begin
        if (memRspValid) begin
          stb.capLen = 1'b1;
          nxt = ST_REQ_ADDR;
        end
      end
      ST_REQ_ADDR: begin
        memReqValid = 1'b1;
        stb.fetchHi = 1'b1;
        if (memReqReady) nxt = ST_WAIT_ADDR;
      end
      ST_WAIT_ADDR: begin
        if (memRspValid) begin
          stb.capAddr = 1'b1;
          nxt = ST_EMIT;
        end
      end
      ST_EMIT: begin
        segValid = 1'b1;
        segLast  = descLast | atCap;
        if (segReady) begin
          if (segLast) begin
            nxt = ST_IDLE;
          end else begin
            stb.advance = 1'b1;
            nxt = ST_REQ_LEN;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign finishNow = segValid && segReady && segLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      walkDone <= 1'b0;
      walkErr  <= 1'b0;
    end else begin
      state    <= nxt;
      walkDone <= finishNow;
      walkErr  <= finishNow && !descLast;
    end
  end

  // R1: idle block drives no request and no segment
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    startReady |-> (!memReqValid && !segValid));

  // R9: request stays up until taken
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);

  // R6: acceptance of the final segment is followed by done and idle
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    (segValid && segReady && segLast) |=> (walkDone && startReady));

  // R7: error only ever accompanies completion
  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    walkErr |-> walkDone);

  // R10: busy block does not react to a start command
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!startReady && startValid && !segValid) |=> !startReady);

endmodule

// File: rtl/sg_seg_walker.sv
module sg_seg_walker
  import sg_walk_pkg::*;
#(
  parameter int MAX_ENTRIES = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  output logic        startReady,
  input  logic [31:0] startBase,
  input  logic [31:0] startLen,
  input  logic        startSgEn,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [31:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  output logic        segValid,
  input  logic        segReady,
  output logic [31:0] segAddr,
  output logic [27:0] segLen,
  output logic        segLast,
  output logic        walkDone,
  output logic        walkErr
);

  walkStrobes_t stb;
  logic descLast;
  logic atCap;

  sg_walk_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startValid  (startValid),
    .startSgEn   (startSgEn),
    .startReady  (startReady),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .segValid    (segValid),
    .segReady    (segReady),
    .segLast     (segLast),
    .walkDone    (walkDone),
    .walkErr     (walkErr),
    .descLast    (descLast),
    .atCap       (atCap),
    .stb         (stb)
  );

  sg_walk_dpath #(.MAX_ENTRIES(MAX_ENTRIES)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .startBase  (startBase),
    .startLen   (startLen),
    .memRspData (memRspData),
    .reqAddr    (memReqAddr),
    .segAddr    (segAddr),
    .segLen     (segLen),
    .descLast   (descLast),
    .atCap      (atCap)
  );

  // R8: a stalled segment keeps all its fields
  p_seg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (segValid && !segReady) |=> (segValid && $stable(segAddr) && $stable(segLen) && $stable(segLast)));

  // R9: a stalled request keeps its address
  p_req_addr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr));

endmodule

// File: tb/tb_sg_seg_walker.sv
module tb_sg_seg_walker;

  localparam int CLK_PERIOD = 10;
  localparam int MAXE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [31:0] startBase = '0;
  logic [31:0] startLen = '0;
  logic startSgEn = 1'b0;
  logic startReady, memReqValid, memReqReady, memRspValid;
  logic [31:0] memReqAddr, memRspData;
  logic segValid, segReady, segLast, walkDone, walkErr;
  logic [31:0] segAddr;
  logic [27:0] segLen;

  always #(CLK_PERIOD/2) clk = ~clk;

  sg_seg_walker #(.MAX_ENTRIES(MAXE)) dut (.*);

  logic [31:0] mem [0:63];
  logic stallOn = 1'b0;
  int cyc = 0;
  assign memReqReady = !stallOn || cyc[0];
  assign segReady    = !stallOn || (cyc % 3 != 0);

  logic [31:0] reqLog [0:255];
  logic [31:0] segALog [0:255];
  logic [27:0] segLLog [0:255];
  logic        segELog [0:255];
  int reqCount = 0, segCount = 0, doneCount = 0, errCount = 0;
  int checks = 0, fails = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    memRspValid <= 1'b0;
    if (rstN) begin
      if (memReqValid && memReqReady) begin
        memRspValid <= 1'b1;
        memRspData  <= mem[memReqAddr[7:2]];
        reqLog[reqCount[7:0]] <= memReqAddr;
        reqCount <= reqCount + 1;
      end
      if (segValid && segReady) begin
        segALog[segCount[7:0]] <= segAddr;
        segLLog[segCount[7:0]] <= segLen;
        segELog[segCount[7:0]] <= segLast;
        segCount <= segCount + 1;
      end
      if (walkDone) doneCount <= doneCount + 1;
      if (walkErr)  errCount  <= errCount + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int sB, rB, dB, eB;

  task automatic runWalk(input logic [31:0] base, input logic [31:0] len, input logic sg);
    sB = segCount; rB = reqCount; dB = doneCount; eB = errCount;
    @(negedge clk);
    startBase = base; startLen = len; startSgEn = sg; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    for (int t = 0; t < 3000 && doneCount == dB; t++) @(negedge clk);
    check(doneCount != dB, "R6 walk timeout", 32'(doneCount), 32'(dB + 1));
    @(negedge clk);
  endtask

  task automatic testReset();
    check(startReady == 1'b1, "R1 startReady", 32'(startReady), 1);
    check(!memReqValid && !segValid && !segLast, "R1 outputs idle",
          {29'd0, memReqValid, segValid, segLast}, 0);
    check(!walkDone && !walkErr, "R1 pulses low", {30'd0, walkDone, walkErr}, 0);
  endtask

  task automatic testDirect();
    runWalk(32'hA000_1234, 32'hF123_4567, 1'b0);
    check(segCount - sB == 1, "R2 segment count", 32'(segCount - sB), 1);
    check(segALog[sB[7:0]] == 32'hA000_1234, "R2 segAddr", segALog[sB[7:0]], 32'hA000_1234);
    check(segLLog[sB[7:0]] == 28'h1234567, "R2 segLen", 32'(segLLog[sB[7:0]]), 32'h1234567);
    check(segELog[sB[7:0]] == 1'b1, "R2 segLast", 32'(segELog[sB[7:0]]), 1);
    check(reqCount == rB, "R2 no memory request", 32'(reqCount - rB), 0);
    check(errCount == eB, "R2 no error", 32'(errCount - eB), 0);
  endtask

  task automatic testThree();
    runWalk(32'h40, 32'h0, 1'b1);
    check(reqCount - rB == 6, "R6 request count", 32'(reqCount - rB), 6);
    for (int k = 0; k < 6; k++)
      check(reqLog[8'(rB + k)] == 32'h40 + 32'(4 * k), "R3 request address order",
            reqLog[8'(rB + k)], 32'h40 + 32'(4 * k));
    check(segCount - sB == 3, "R6 segment count", 32'(segCount - sB), 3);
    check(segLLog[8'(sB)] == 28'h10, "R4 len seg0", 32'(segLLog[8'(sB)]), 32'h10);
    check(segLLog[8'(sB + 1)] == 28'h20, "R4 len bits 30:28 ignored", 32'(segLLog[8'(sB + 1)]), 32'h20);
    check(segLLog[8'(sB + 2)] == 28'h30, "R4 len seg2", 32'(segLLog[8'(sB + 2)]), 32'h30);
    check(segELog[8'(sB)] == 0 && segELog[8'(sB + 1)] == 0 && segELog[8'(sB + 2)] == 1,
          "R4 last flags", {29'd0, segELog[8'(sB)], segELog[8'(sB + 1)], segELog[8'(sB + 2)]}, 1);
    check(segALog[8'(sB)] == 32'h0000_1000, "R5 addr bit31 cleared", segALog[8'(sB)], 32'h1000);
    check(segALog[8'(sB + 1)] == 32'h1234_5678, "R5 addr passthrough", segALog[8'(sB + 1)], 32'h12345678);
    check(segALog[8'(sB + 2)] == 32'h7FFF_FFF0, "R5 addr top mask", segALog[8'(sB + 2)], 32'h7FFFFFF0);
    check(doneCount - dB == 1, "R6 single done pulse", 32'(doneCount - dB), 1);
    check(errCount == eB, "R6 no error", 32'(errCount - eB), 0);
  endtask

  task automatic testStalled();
    stallOn = 1'b1;
    runWalk(32'h80, 32'h0, 1'b1);
    check(reqCount - rB == 2, "R9 one descriptor requests", 32'(reqCount - rB), 2);
    check(reqLog[8'(rB)] == 32'h80 && reqLog[8'(rB + 1)] == 32'h84, "R9 stalled request addresses",
          reqLog[8'(rB + 1)], 32'h84);
    check(segCount - sB == 1, "R8 stalled segment count", 32'(segCount - sB), 1);
    check(segLLog[8'(sB)] == 28'hBCDEF0 && segALog[8'(sB)] == 32'h2000, "R8 stalled segment fields",
          32'(segLLog[8'(sB)]), 32'hBCDEF0);
    runWalk(32'h40, 32'h0, 1'b1);
    check(segCount - sB == 3 && segALog[8'(sB + 1)] == 32'h1234_5678, "R8 three segments under stall",
          32'(segCount - sB), 3);
    stallOn = 1'b0;
  endtask

  task automatic testCap();
    runWalk(32'h00, 32'h0, 1'b1);
    check(reqCount - rB == 2 * MAXE, "R7 fetch stops at cap", 32'(reqCount - rB), 32'(2 * MAXE));
    check(segCount - sB == MAXE, "R7 segments at cap", 32'(segCount - sB), 32'(MAXE));
    check(segELog[8'(sB + MAXE - 1)] == 1 && segELog[8'(sB + MAXE - 2)] == 0, "R7 cap forces last",
          32'(segELog[8'(sB + MAXE - 1)]), 1);
    check(segALog[8'(sB + MAXE - 1)] == 32'h400, "R7 capped segment addr", segALog[8'(sB + MAXE - 1)], 32'h400);
    check(errCount - eB == 1, "R7 error pulse", 32'(errCount - eB), 1);
    runWalk(32'hC0, 32'h0, 1'b1);
    check(segCount - sB == MAXE && segELog[8'(sB + MAXE - 1)] == 1, "R7 end bit on capped entry",
          32'(segCount - sB), 32'(MAXE));
    check(errCount == eB, "R7 no error when end bit at cap", 32'(errCount - eB), 0);
  endtask

  task automatic testBusyStart();
    sB = segCount; rB = reqCount; dB = doneCount; eB = errCount;
    stallOn = 1'b1;
    @(negedge clk);
    startBase = 32'h40; startSgEn = 1'b1; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    repeat (3) @(negedge clk);
    startBase = 32'h80; startSgEn = 1'b0; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    for (int t = 0; t < 3000 && doneCount == dB; t++) @(negedge clk);
    repeat (5) @(negedge clk);
    stallOn = 1'b0;
    check(doneCount - dB == 1, "R10 one walk only", 32'(doneCount - dB), 1);
    check(segCount - sB == 3, "R10 segments of first walk", 32'(segCount - sB), 3);
    check(reqCount - rB == 6 && reqLog[8'(rB)] == 32'h40, "R10 requests of first walk",
          32'(reqCount - rB), 6);
  endtask

  initial begin
    for (int w = 0; w < 64; w++) mem[w] = '0;
    // cap walk at 0x00: no end bits
    mem[0] = 32'h1; mem[1] = 32'h100;
    mem[2] = 32'h2; mem[3] = 32'h200;
    mem[4] = 32'h3; mem[5] = 32'h300;
    mem[6] = 32'h4; mem[7] = 32'h400;
    // three-entry walk at 0x40
    mem[16] = 32'h0000_0010; mem[17] = 32'h8000_1000;
    mem[18] = 32'h7000_0020; mem[19] = 32'h1234_5678;
    mem[20] = 32'h8000_0030; mem[21] = 32'hFFFF_FFF0;
    // single entry at 0x80
    mem[32] = 32'h80BC_DEF0; mem[33] = 32'h0000_2000;
    // end bit exactly on the capped entry at 0xC0
    mem[48] = 32'h5; mem[49] = 32'h10;
    mem[50] = 32'h6; mem[51] = 32'h20;
    mem[52] = 32'h7; mem[53] = 32'h30;
    mem[54] = 32'h8000_0008; mem[55] = 32'h40;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirect();
    testThree();
    testStalled();
    testCap();
    testBusyStart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule